// File: doc/BRIEF.md
# Shared Partition Pool Allocator

This block decides which core owns each partition of a storage structure that several cores share, such as a register file or a reorder buffer cut into equal, self-contained slices. Every partition is either owned by one core or free. Each cycle every core may ask for one more partition and may hand back one partition it owns. A single central arbiter settles competing asks, and every core's holding is kept between a floor and a ceiling.

The decision is made every cycle, so a slice handed back in one cycle can go to another core in the next. A slice can be handed back only when the storage side reports it has no live entries. The block does not hold the storage arrays, does not steer data to a slice, and does not decide when a core should ask for more.

Top module: `palloc_pool`

## Requirements
- R1: After reset, core c owns partitions c*MIN to c*MIN+MIN-1 (defaults: 4 cores, 16 partitions, MIN 2, MAX 4). Every other partition is free, each core count equals MIN, the free count is 16-4*2 = 8 and no grant is raised.
- R2: At most one partition is granted per cycle. A grow request sampled at a clock edge shows up after that edge as a one-hot bit in `grant_vld`, with `grant_part` holding the lowest-numbered free partition. The ownership outputs change at the same edge.
- R3: A grow request from a core that already holds MAX partitions is denied.
- R4: Among eligible requesters, the winner is the first core at or after a rotating pointer. The pointer starts at core 0 and moves to the core after the winner. It stays put in cycles with no grant.
- R5: A release is applied only when three conditions hold: the requesting core owns the named partition, that partition's empty flag is 1, and the core holds more than MIN partitions. Otherwise the partition stays with its owner.
- R6: No grant is made while the free count is zero.
- R7: Each core count equals the number of partitions it owns, and lies between MIN and MAX. The sum of the core counts plus the free count always equals the number of partitions.
- R8: A release and a grant in the same cycle are both applied. A partition released in one cycle is not granted in that cycle, but can be granted in the next.
- R9: A core below MAX that keeps asking while free partitions exist is granted within one pointer rotation (at most 4 cycles).

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grow_req | input | 4 | Per-core request for one more partition |
| rel_req | input | 4 | Per-core request to hand back a partition |
| rel_part | input | 16 | Partition index named by each core's release, 4 bits per core |
| part_empty | input | 16 | Per-partition flag: no live entries |
| grant_vld | output | 4 | One-hot grant to the winning core |
| grant_part | output | 4 | Index of the granted partition |
| part_busy | output | 16 | Per-partition owned flag |
| part_owner | output | 32 | Owner core of each partition, 2 bits per partition |
| core_cnt | output | 20 | Owned partition count per core, 5 bits per core |
| free_cnt | output | 5 | Number of free partitions |

## Verification
The assertions check every cycle that the grants are one-hot and traced to a request from a core below its ceiling, and that no grant is made while the free count is zero. They also check that the counts agree with the ownership map and add up to the pool size, and that a partition only becomes free after its empty flag was set. The bench scenarios cover what a single-cycle property cannot show: the order in which the rotating pointer serves cores, the choice of the lowest free slot, refused releases (wrong owner, not empty, at the floor), reuse in the next cycle of a slice just handed back, and service of a requester that keeps asking.

// File: rtl/palloc_pkg.sv
package palloc_pkg;

    localparam int unsigned PA_CORES = 4;
    localparam int unsigned PA_PARTS = 16;
    localparam int unsigned PA_MIN   = 2;
    localparam int unsigned PA_MAX   = 4;

    localparam int unsigned PA_CW = $clog2(PA_CORES);
    localparam int unsigned PA_PW = $clog2(PA_PARTS);
    localparam int unsigned PA_NW = $clog2(PA_PARTS + 1);

    typedef logic [PA_CW-1:0] core_id_t;
    typedef logic [PA_PW-1:0] part_id_t;
    typedef logic [PA_NW-1:0] part_cnt_t;

    typedef struct packed {
        logic     busy;
        core_id_t owner;
    } slot_t;

    function automatic slot_t slot_at_reset(int unsigned p);
        slot_t s;
        s.busy  = (p < PA_CORES * PA_MIN);
        s.owner = s.busy ? core_id_t'(p / PA_MIN) : '0;
        return s;
    endfunction

endpackage

// File: rtl/palloc_pick.sv
module palloc_pick #(
    parameter int unsigned N  = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  avail,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/palloc_rr.sv
module palloc_rr #(
    parameter int unsigned N  = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] win
);
    logic [IW-1:0] ptr_q;

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (req[j]) begin
                any = 1'b1;
                win = IW'(j);
            end
        end
        gnt = any ? (N'(1) << win) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take && any) begin
            ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end

    AST_RR_WIN_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        any |-> ((gnt & req) == gnt)); // R4
endmodule

// File: rtl/palloc_pool.sv
module palloc_pool
    import palloc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [PA_CORES-1:0]          grow_req,
    input  logic [PA_CORES-1:0]          rel_req,
    input  logic [PA_CORES*PA_PW-1:0]    rel_part,
    input  logic [PA_PARTS-1:0]          part_empty,
    output logic [PA_CORES-1:0]          grant_vld,
    output logic [PA_PW-1:0]             grant_part,
    output logic [PA_PARTS-1:0]          part_busy,
    output logic [PA_PARTS*PA_CW-1:0]    part_owner,
    output logic [PA_CORES*PA_NW-1:0]    core_cnt,
    output logic [PA_NW-1:0]             free_cnt
);
    slot_t     map_q [PA_PARTS];
    part_cnt_t cnt_q [PA_CORES];
    part_cnt_t free_q;

    logic [PA_PARTS-1:0] avail;
    logic                have_free;
    part_id_t            pick_idx;
    logic [PA_CORES-1:0] elig, arb_gnt, rel_ok;
    logic                arb_any, do_grant;
    core_id_t            arb_win;
    logic [PA_PARTS-1:0] drop;

    always_comb begin
        for (int p = 0; p < PA_PARTS; p++) avail[p] = !map_q[p].busy;
        for (int c = 0; c < PA_CORES; c++) begin
            part_id_t rp;
            rp      = rel_part[c*PA_PW +: PA_PW];
            elig[c] = grow_req[c] && (cnt_q[c] < part_cnt_t'(PA_MAX));
            rel_ok[c] = rel_req[c] && map_q[rp].busy
                     && (map_q[rp].owner == core_id_t'(c))
                     && part_empty[rp]
                     && (cnt_q[c] > part_cnt_t'(PA_MIN));
        end
        drop = '0;
        for (int c = 0; c < PA_CORES; c++)
            if (rel_ok[c]) drop[rel_part[c*PA_PW +: PA_PW]] = 1'b1;
    end

    palloc_pick #(.N(PA_PARTS)) i_pick (
        .avail (avail),
        .found (have_free),
        .idx   (pick_idx)
    );

    palloc_rr #(.N(PA_CORES)) i_rr (
        .clk  (clk),
        .rst  (rst),
        .req  (elig),
        .take (have_free),
        .any  (arb_any),
        .gnt  (arb_gnt),
        .win  (arb_win)
    );

    assign do_grant = have_free && arb_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PA_PARTS; p++) map_q[p] <= slot_at_reset(p);
            for (int c = 0; c < PA_CORES; c++) cnt_q[c] <= part_cnt_t'(PA_MIN);
            free_q     <= part_cnt_t'(PA_PARTS - PA_CORES * PA_MIN);
            grant_vld  <= '0;
            grant_part <= '0;
        end else begin
            for (int p = 0; p < PA_PARTS; p++) begin
                if (drop[p]) begin
                    map_q[p].busy <= 1'b0;
                end else if (do_grant && (pick_idx == part_id_t'(p))) begin
                    map_q[p].busy  <= 1'b1;
                    map_q[p].owner <= arb_win;
                end
            end
            for (int c = 0; c < PA_CORES; c++)
                cnt_q[c] <= cnt_q[c] + part_cnt_t'(do_grant && arb_gnt[c])
                                     - part_cnt_t'(rel_ok[c]);
            free_q     <= free_q + part_cnt_t'($countones(rel_ok)) - part_cnt_t'(do_grant);
            grant_vld  <= do_grant ? arb_gnt : '0;
            grant_part <= do_grant ? pick_idx : '0;
        end
    end

    always_comb begin
        for (int p = 0; p < PA_PARTS; p++) begin
            part_busy[p]                  = map_q[p].busy;
            part_owner[p*PA_CW +: PA_CW]  = map_q[p].owner;
        end
        for (int c = 0; c < PA_CORES; c++) core_cnt[c*PA_NW +: PA_NW] = cnt_q[c];
        free_cnt = free_q;
    end

    // checks on every cycle
    part_cnt_t chk_owned [PA_CORES];
    int unsigned chk_total;
    always_comb begin
        chk_total = int'(free_q);
        for (int c = 0; c < PA_CORES; c++) begin
            chk_owned[c] = '0;
            for (int p = 0; p < PA_PARTS; p++)
                if (map_q[p].busy && map_q[p].owner == core_id_t'(c))
                    chk_owned[c] = chk_owned[c] + 1'b1;
            chk_total = chk_total + int'(cnt_q[c]);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vld)); // R2
    AST_NO_GRANT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (|grant_vld) |-> ($past(free_q) != '0)); // R6
    AST_POOL_CONSERVED: assert property (@(posedge clk) disable iff (rst)
        chk_total == PA_PARTS); // R7

    for (genvar gc = 0; gc < PA_CORES; gc++) begin : g_core_chk
        AST_GRANT_HAD_REQUEST: assert property (@(posedge clk) disable iff (rst)
            grant_vld[gc] |-> $past(grow_req[gc])); // R2
        AST_GRANT_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
            grant_vld[gc] |-> ($past(cnt_q[gc]) < part_cnt_t'(PA_MAX))); // R3
        AST_COUNT_MATCHES_MAP: assert property (@(posedge clk) disable iff (rst)
            cnt_q[gc] == chk_owned[gc]); // R7
        AST_COUNT_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[gc] >= part_cnt_t'(PA_MIN)) && (cnt_q[gc] <= part_cnt_t'(PA_MAX))); // R7
    end

    for (genvar gp = 0; gp < PA_PARTS; gp++) begin : g_part_chk
        AST_FREED_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
            (!map_q[gp].busy && $past(map_q[gp].busy)) |-> $past(part_empty[gp])); // R5
    end
endmodule

// File: tb/test_palloc_pool.sv
module test_palloc_pool;
    import palloc_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [PA_CORES-1:0]       grow_req = '0;
    logic [PA_CORES-1:0]       rel_req = '0;
    logic [PA_CORES*PA_PW-1:0] rel_part = '0;
    logic [PA_PARTS-1:0]       part_empty = '1;
    logic [PA_CORES-1:0]       grant_vld;
    logic [PA_PW-1:0]          grant_part;
    logic [PA_PARTS-1:0]       part_busy;
    logic [PA_PARTS*PA_CW-1:0] part_owner;
    logic [PA_CORES*PA_NW-1:0] core_cnt;
    logic [PA_NW-1:0]          free_cnt;

    int total = 0;
    int bad   = 0;

    palloc_pool i_palloc_pool (
        .clk(clk), .rst(rst), .grow_req(grow_req), .rel_req(rel_req),
        .rel_part(rel_part), .part_empty(part_empty), .grant_vld(grant_vld),
        .grant_part(grant_part), .part_busy(part_busy), .part_owner(part_owner),
        .core_cnt(core_cnt), .free_cnt(free_cnt)
    );

    always #4 clk = ~clk;

    // {grow_req, expected grant_vld, expected grant_part}
    localparam logic [11:0] VEC [10] = '{
        {4'b0001, 4'b0001, 4'd8},   // R2 lowest free slot, pointer at core 0
        {4'b1111, 4'b0010, 4'd9},   // R4 pointer moved to core 1
        {4'b1111, 4'b0100, 4'd10},  // R4
        {4'b1111, 4'b1000, 4'd11},  // R4 R9 every core served in one rotation
        {4'b1111, 4'b0001, 4'd12},  // R4 wraps, core 0 reaches MAX
        {4'b0001, 4'b0000, 4'd0},   // R3 core 0 at MAX denied
        {4'b1001, 4'b1000, 4'd13},  // R3 R4 core 3 wins past denied core 0
        {4'b0110, 4'b0010, 4'd14},  // R4
        {4'b0110, 4'b0100, 4'd15},  // R4 pool now empty
        {4'b1111, 4'b0000, 4'd0}    // R6 no free slot
    };

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; grow_req = '0; rel_req = '0; part_empty = '1;
        step(); step();
        rst = 1'b0;
    endtask

    function automatic int cnt_of(int c);
        return int'(core_cnt[c*PA_NW +: PA_NW]);
    endfunction

    function automatic int own_of(int p);
        return int'(part_owner[p*PA_CW +: PA_CW]);
    endfunction

    initial begin
        #1600000;
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 free", int'(free_cnt), 8);
        chk("R1 busy", int'(part_busy), 16'h00FF);
        chk("R1 owner5", own_of(5), 2);
        chk("R1 owner7", own_of(7), 3);
        chk("R1 grant", int'(grant_vld), 0);
        for (int c = 0; c < PA_CORES; c++) chk("R1 count", cnt_of(c), 2);

        for (int i = 0; i < 10; i++) begin
            grow_req = VEC[i][11:8];
            step();
            chk("R2 R3 R4 R6 grant", int'(grant_vld), int'(VEC[i][7:4]));
            if (VEC[i][7:4] != 4'b0) chk("R2 slot", int'(grant_part), int'(VEC[i][3:0]));
        end
        grow_req = '0;
        chk("R7 free", int'(free_cnt), 0);
        for (int c = 0; c < PA_CORES; c++) chk("R7 count", cnt_of(c), 4);

        // R5 wrong owner: core 1 names slot 8 held by core 0
        rel_req = 4'b0010; rel_part = '0; rel_part[1*PA_PW +: PA_PW] = 4'd8;
        step();
        chk("R5 wrong owner busy", int'(part_busy[8]), 1);
        chk("R5 wrong owner owner", own_of(8), 0);
        // R5 slot not empty
        rel_req = 4'b0001; rel_part = '0; rel_part[0 +: PA_PW] = 4'd8;
        part_empty = '1; part_empty[8] = 1'b0;
        step();
        chk("R5 not empty busy", int'(part_busy[8]), 1);
        // R5 accepted
        part_empty = '1;
        step();
        rel_req = '0;
        chk("R5 accepted busy", int'(part_busy[8]), 0);
        chk("R5 accepted count", cnt_of(0), 3);
        chk("R5 accepted free", int'(free_cnt), 1);

        // R8 grant to core 0 and release by core 1 in one cycle
        grow_req = 4'b0001;
        rel_req = 4'b0010; rel_part = '0; rel_part[1*PA_PW +: PA_PW] = 4'd9;
        step();
        grow_req = '0; rel_req = '0;
        chk("R8 grant", int'(grant_vld), 1);
        chk("R8 slot", int'(grant_part), 8);
        chk("R8 count0", cnt_of(0), 4);
        chk("R8 count1", cnt_of(1), 3);
        chk("R8 free", int'(free_cnt), 1);
        chk("R8 freed", int'(part_busy[9]), 0);
        // R8 released slot reused next
        grow_req = 4'b0010;
        step();
        grow_req = '0;
        chk("R8 reuse grant", int'(grant_vld), 2);
        chk("R8 reuse slot", int'(grant_part), 9);
        chk("R8 reuse owner", own_of(9), 1);

        // R5 floor: core at MIN cannot release
        do_reset();
        rel_req = 4'b0001; rel_part = '0;
        step();
        rel_req = '0;
        chk("R5 floor busy", int'(part_busy[0]), 1);
        chk("R5 floor count", cnt_of(0), 2);

        // R9 core 3 keeps asking while core 0 also asks
        grow_req = 4'b1001;
        step();
        chk("R9 first", int'(grant_vld), 1);
        step();
        grow_req = '0;
        chk("R9 core3 served", int'(grant_vld), 8);
        chk("R9 core3 slot", int'(grant_part), 9);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule